// File: doc/BRIEF.md
# HDLC Test and Loopback Router

This block sits between a processor register port, a pair of packet FIFOs (transmit and receive) and an abstract serial HDLC transmitter and receiver. Each FIFO entry is a data byte together with a two-bit tag that marks the byte as ordinary data, as the last byte of a good or bad packet, or as a frame abort. A test control register decides how data moves between these parts. Its settings cover normal operation, echoing received packets back to the transmitter, feeding the serial output straight back into the receiver, and swapping the processor's FIFO access so that FIFO status logic can be tested without any serial traffic.

Software writes entries into the transmit FIFO through a single data port. With transmission enabled, the serializer sends each entry as ten bits, least significant bit first. The deserializer gathers ten-bit words into the receive FIFO, and software reads them back through the same data port. A self-holding soft reset bit in the test register clears all of this logic except the bit itself, so software can hold the path idle for as long as it needs.

Top module: `hdlc_test_router`

## Requirements
- R1: After the hardware reset `rst`, the test register and the control register read 0. Both FIFOs are empty, so the status register reads 0xC. `ser_tx_valid` is low.
- R2: While the soft reset bit (test bit 5) is 1, test bits 4..0 and the control register read 0 and ignore writes. Both FIFOs are emptied and ignore data-port writes. The bit stays 1 until software writes 0 to it.
- R3: The hardware reset clears the soft reset bit.
- R4: Entries are 10 bits wide: data in bits 7..0 and tag in bits 9..8 (00 data, 01 end of good packet, 10 end of bad packet, 11 abort). A data-port write (address 2) places an entry in the transmit FIFO. When transmit enable (control bit 1) is set, each entry is sent in order as 10 bits on `ser_tx_bit`, least significant bit first, one bit per cycle in which `ser_tx_valid` is high.
- R5: When receive enable (control bit 0) is set, every 10 valid serial input bits, least significant bit first, form one entry in the receive FIFO. A data-port read returns the oldest entry on `cpu_rdata` one cycle after the read strobe. When receive enable is 0, serial input is ignored.
- R6: With the receive-to-transmit bit (test bit 4) set, every received entry is also written to the transmit FIFO, whatever its tag, and is sent when transmit enable is set.
- R7: With the transmit-to-receive bit (test bit 0) set and both enables set, the receiver takes its input from the transmitter output and ignores `ser_rx_valid`/`ser_rx_bit`. If either enable is clear, the external serial input is used.
- R8: When test bits 4 and 0 are both set, received entries are not copied into the transmit FIFO, so a looped packet is sent only once.
- R9: With the FIFO-test bit (test bit 2) set, data-port writes go to the receive FIFO and data-port reads pop the transmit FIFO. The serializer does not pop the transmit FIFO in this mode.
- R10: The status register (address 3) reads bit 3 = receive FIFO empty and bit 2 = transmit FIFO empty. Bits 1..0 hold the tag of the entry last popped from the transmit FIFO.
- R11: Each FIFO holds 16 entries. A write to a full FIFO is dropped, and the stored entries come out unchanged.
- R12: The CRC-test bit (test bit 3) and the address-test bit (test bit 1) read back as written and do not alter the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_addr | input | 2 | 0 test register, 1 control, 2 data port, 3 status |
| cpu_wdata | input | 10 | Write data (entry or register value) |
| cpu_rdata | output | 10 | Read data, valid one cycle after `cpu_rd` |
| ser_rx_valid | input | 1 | External serial input bit valid |
| ser_rx_bit | input | 1 | External serial input bit |
| ser_tx_valid | output | 1 | Serial output bit valid |
| ser_tx_bit | output | 1 | Serial output bit |

## Verification
A stale or wrong mode bit shows up at the serial output within about a dozen cycles, as a word that is missing, extra or repeated. An echo loop in particular makes the transmitter send the same word forever, so counting output words over a fixed window exposes it. A corrupted FIFO pointer or count shows on the next data-port or status read, as the wrong entry or a wrong empty flag. If soft reset fails to clear state, the register read-backs and the status read taken straight after the reset bit is set show it.

// File: rtl/hdlc_tr_pkg.sv
package hdlc_tr_pkg;
  localparam int TAG_W = 2;

  typedef enum logic [1:0] {
    TAG_DATA    = 2'b00,
    TAG_EOP_OK  = 2'b01,
    TAG_EOP_BAD = 2'b10,
    TAG_ABORT   = 2'b11
  } tag_e;

  // processor register map
  localparam logic [1:0] A_TEST = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  // test register bit positions
  localparam int B_SOFT = 5;
  localparam int B_R2T  = 4;
  localparam int B_CRC  = 3;
  localparam int B_FIFO = 2;
  localparam int B_ADDR = 1;
  localparam int B_T2R  = 0;

  typedef enum logic [1:0] {SRC_REG, SRC_RXQ, SRC_TXQ} rsrc_e;
endpackage

// File: rtl/hdlc_fifo.sv
module hdlc_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           push,
  input  logic [W-1:0]   din,
  input  logic           pop,
  output logic [W-1:0]   dout,
  output logic           empty,
  output logic           full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop) begin
        dout <= mem[rp];
        rp   <= rp + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_ser_tx.sv
module hdlc_ser_tx #(
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  input  logic          q_empty,
  input  logic [EW-1:0] q_dout,
  output logic          q_pop,
  output logic          out_valid,
  output logic          out_bit
);
  localparam int CW = $clog2(EW + 1);

  logic          busy_q, load_q;
  logic [EW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign q_pop = en && !busy_q && !load_q && !q_empty;

  always_ff @(posedge clk) begin
    if (clr) begin
      busy_q    <= 1'b0;
      load_q    <= 1'b0;
      sh_q      <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      load_q    <= q_pop;
      out_valid <= 1'b0;
      if (load_q) begin
        sh_q   <= q_dout;
        cnt_q  <= CW'(EW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        out_valid <= 1'b1;
        out_bit   <= sh_q[0];
        sh_q      <= sh_q >> 1;
        cnt_q     <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_ser_rx.sv
module hdlc_ser_rx #(
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          word_v,
  output logic [EW-1:0] word
);
  localparam int CW = $clog2(EW + 1);

  logic [EW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr || !en) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_v <= 1'b0;
      if (clr) word <= '0;
    end else begin
      word_v <= 1'b0;
      if (in_valid) begin
        sh_q <= {in_bit, sh_q[EW-1:1]};
        if (cnt_q == CW'(EW - 1)) begin
          cnt_q  <= '0;
          word_v <= 1'b1;
          word   <= {in_bit, sh_q[EW-1:1]};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_test_router.sv
module hdlc_test_router
  import hdlc_tr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic [1:0]          cpu_addr,
  input  logic [DATA_W+1:0]   cpu_wdata,
  output logic [DATA_W+1:0]   cpu_rdata,
  input  logic                ser_rx_valid,
  input  logic                ser_rx_bit,
  output logic                ser_tx_valid,
  output logic                ser_tx_bit
);
  localparam int EW = DATA_W + TAG_W;
  localparam int CNTW = $clog2(DEPTH) + 1;

  // register state
  logic       soft_q;
  logic [4:0] tbits_q;
  logic       rx_en_q, tx_en_q;
  logic       irst;

  logic wr_test, wr_ctrl, wr_data, rd_data;
  logic fifo_test, r2t_on, t2r_on, t2r_act;

  assign irst    = rst || soft_q;
  assign wr_test = cpu_wr && (cpu_addr == A_TEST);
  assign wr_ctrl = cpu_wr && (cpu_addr == A_CTRL);
  assign wr_data = cpu_wr && (cpu_addr == A_DATA);
  assign rd_data = cpu_rd && (cpu_addr == A_DATA);

  assign fifo_test = tbits_q[B_FIFO];
  assign r2t_on    = tbits_q[B_R2T];
  assign t2r_on    = tbits_q[B_T2R];
  assign t2r_act   = t2r_on && rx_en_q && tx_en_q;

  // soft reset bit: cleared only by hardware reset or a write of 0
  always_ff @(posedge clk) begin
    if (rst)          soft_q <= 1'b0;
    else if (wr_test) soft_q <= cpu_wdata[B_SOFT];
  end

  always_ff @(posedge clk) begin
    if (irst)         tbits_q <= '0;
    else if (wr_test) tbits_q <= cpu_wdata[B_SOFT] ? 5'b0 : cpu_wdata[4:0];
  end

  always_ff @(posedge clk) begin
    if (irst) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      rx_en_q <= cpu_wdata[0];
      tx_en_q <= cpu_wdata[1];
    end
  end

  // receiver with loopback input select
  logic          rx_vin, rx_bin;
  logic          rw_v;
  logic [EW-1:0] rw;

  assign rx_vin = t2r_act ? ser_tx_valid : ser_rx_valid;
  assign rx_bin = t2r_act ? ser_tx_bit   : ser_rx_bit;

  hdlc_ser_rx #(.EW(EW)) rx_i (
    .clk      (clk),
    .clr      (irst),
    .en       (rx_en_q),
    .in_valid (rx_vin),
    .in_bit   (rx_bin),
    .word_v   (rw_v),
    .word     (rw)
  );

  // FIFO port steering
  logic            rxq_push, rxq_pop, rxq_empty, rxq_full;
  logic            txq_push, txq_pop, txq_empty, txq_full;
  logic [EW-1:0]   rxq_din, rxq_dout, txq_din, txq_dout;
  logic [CNTW-1:0] rxq_cnt, txq_cnt;
  logic            copy_v, ser_pop, ser_en;

  assign copy_v   = rw_v && r2t_on && !t2r_on;
  assign rxq_push = rw_v || (fifo_test && wr_data);
  assign rxq_din  = rw_v ? rw : cpu_wdata;
  assign rxq_pop  = !fifo_test && rd_data;
  assign txq_push = copy_v || (!fifo_test && wr_data);
  assign txq_din  = copy_v ? rw : cpu_wdata;
  assign txq_pop  = ser_pop || (fifo_test && rd_data);
  assign ser_en   = tx_en_q && !fifo_test;

  hdlc_fifo #(.W(EW), .DEPTH(DEPTH)) rxq_i (
    .clk   (clk),
    .clr   (irst),
    .push  (rxq_push),
    .din   (rxq_din),
    .pop   (rxq_pop),
    .dout  (rxq_dout),
    .empty (rxq_empty),
    .full  (rxq_full),
    .count (rxq_cnt)
  );

  hdlc_fifo #(.W(EW), .DEPTH(DEPTH)) txq_i (
    .clk   (clk),
    .clr   (irst),
    .push  (txq_push),
    .din   (txq_din),
    .pop   (txq_pop),
    .dout  (txq_dout),
    .empty (txq_empty),
    .full  (txq_full),
    .count (txq_cnt)
  );

  hdlc_ser_tx #(.EW(EW)) tx_i (
    .clk       (clk),
    .clr       (irst),
    .en        (ser_en),
    .q_empty   (txq_empty),
    .q_dout    (txq_dout),
    .q_pop     (ser_pop),
    .out_valid (ser_tx_valid),
    .out_bit   (ser_tx_bit)
  );

  // read path: registered source select and register snapshot
  rsrc_e         rsrc_q;
  logic [EW-1:0] reg_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsrc_q   <= SRC_REG;
      reg_rd_q <= '0;
    end else if (cpu_rd) begin
      rsrc_q <= SRC_REG;
      case (cpu_addr)
        A_TEST:  reg_rd_q <= EW'({soft_q, tbits_q});
        A_CTRL:  reg_rd_q <= EW'({tx_en_q, rx_en_q});
        A_STAT:  reg_rd_q <= EW'({rxq_empty, txq_empty, txq_dout[EW-1 -: TAG_W]});
        default: rsrc_q   <= fifo_test ? SRC_TXQ : SRC_RXQ;
      endcase
    end
  end

  always_comb begin
    case (rsrc_q)
      SRC_RXQ: cpu_rdata = rxq_dout;
      SRC_TXQ: cpu_rdata = txq_dout;
      default: cpu_rdata = reg_rd_q;
    endcase
  end
endmodule

// File: rtl/hdlc_test_router_chk.sv
module hdlc_test_router_chk
  import hdlc_tr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    soft_q,
  input logic [4:0]              tbits_q,
  input logic                    rx_en_q,
  input logic                    tx_en_q,
  input logic                    rw_v,
  input logic                    txq_pop,
  input logic                    cpu_wr,
  input logic                    cpu_rd,
  input logic [1:0]              cpu_addr,
  input logic                    ser_tx_valid,
  input logic [$clog2(DEPTH):0]  txq_cnt,
  input logic [$clog2(DEPTH):0]  rxq_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R1
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txq_cnt == '0) && (rxq_cnt == '0) && !ser_tx_valid);

  // R3
  a_r3_hw_clears_soft: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !soft_q);

  // R2
  a_r2_soft_clears_bits: assert property (@(posedge clk) disable iff (rst)
    soft_q |-> (tbits_q == 5'b0));

  // R2
  a_r2_soft_holds_state: assert property (@(posedge clk) disable iff (rst)
    (soft_q && $past(soft_q)) |-> (!rx_en_q && !tx_en_q && txq_cnt == '0 && rxq_cnt == '0));

  // R5
  a_r5_rx_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_en_q) |-> !rw_v);

  // R8
  a_r8_no_echo_in_double_loop: assert property (@(posedge clk) disable iff (rst)
    (tbits_q[B_R2T] && tbits_q[B_T2R] && rw_v && !cpu_wr && !txq_pop)
      |=> (txq_cnt <= $past(txq_cnt)));

  // R9
  a_r9_swap_write_to_rxq: assert property (@(posedge clk) disable iff (rst)
    (tbits_q[B_FIFO] && cpu_wr && cpu_addr == A_DATA && !rw_v && !txq_pop)
      |=> (txq_cnt <= $past(txq_cnt)));

  // R11
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (txq_cnt <= CW'(DEPTH)) && (rxq_cnt <= CW'(DEPTH)));
endmodule

bind hdlc_test_router hdlc_test_router_chk #(.DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .soft_q       (soft_q),
  .tbits_q      (tbits_q),
  .rx_en_q      (rx_en_q),
  .tx_en_q      (tx_en_q),
  .rw_v         (rw_v),
  .txq_pop      (txq_pop),
  .cpu_wr       (cpu_wr),
  .cpu_rd       (cpu_rd),
  .cpu_addr     (cpu_addr),
  .ser_tx_valid (ser_tx_valid),
  .txq_cnt      (txq_cnt),
  .rxq_cnt      (rxq_cnt)
);

// File: tb/hdlc_test_router_tb.sv
module hdlc_test_router_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [9:0] cpu_wdata = '0;
  logic [9:0] cpu_rdata;
  logic       ser_rx_valid = 1'b0, ser_rx_bit = 1'b0;
  logic       ser_tx_valid, ser_tx_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hdlc_test_router dut_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ser_rx_valid(ser_rx_valid),
    .ser_rx_bit(ser_rx_bit), .ser_tx_valid(ser_tx_valid), .ser_tx_bit(ser_tx_bit)
  );

  // serial output monitor: assembles LSB-first 10-bit words
  logic [9:0] mon_sh;
  int         mon_n, nw;
  logic [9:0] mon_w [32];
  always @(negedge clk) begin
    if (rst) begin
      mon_n = 0; nw = 0; mon_sh = '0;
    end else if (ser_tx_valid) begin
      mon_sh = {ser_tx_bit, mon_sh[9:1]};
      mon_n++;
      if (mon_n == 10) begin
        if (nw < 32) mon_w[nw] = mon_sh;
        nw++;
        mon_n = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cpu_wr = 0; cpu_rd = 0; ser_rx_valid = 0; ser_rx_bit = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [9:0] d);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic send_ser(input logic [9:0] w);
    for (int i = 0; i < 10; i++) begin
      ser_rx_valid = 1'b1; ser_rx_bit = w[i];
      @(negedge clk);
    end
    ser_rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [9:0] d;
    do_reset();
    chk("R1 ser_tx_valid", ser_tx_valid, 0);
    rd(2'd0, d); chk("R1 test reg", d, 0);
    rd(2'd1, d); chk("R1 ctrl reg", d, 0);
    rd(2'd3, d); chk("R1 status", d, 10'hC);
  endtask

  task automatic t_normal_tx();
    logic [9:0] d;
    logic [9:0] v [3] = '{10'h0A5, 10'h13C, 10'h2FF};
    do_reset();
    for (int i = 0; i < 3; i++) wr(2'd2, v[i]);
    rd(2'd3, d); chk("R4 tx queued", d[2], 0);
    chk("R4 no output before enable", nw, 0);
    wr(2'd1, 10'h2);
    repeat (60) @(negedge clk);
    chk("R4 word count", nw, 3);
    for (int i = 0; i < 3; i++) chk("R4 serial word", mon_w[i], v[i]);
    rd(2'd3, d); chk("R4 tx drained", d[2], 1);
  endtask

  task automatic t_rx();
    logic [9:0] d;
    do_reset();
    send_ser(10'h155);
    rd(2'd3, d); chk("R5 ignored without enable", d[3], 1);
    wr(2'd1, 10'h1);
    send_ser(10'h3C5);
    send_ser(10'h112);
    rd(2'd2, d); chk("R5 first rx word", d, 10'h3C5);
    rd(2'd2, d); chk("R5 second rx word", d, 10'h112);
    rd(2'd3, d); chk("R5 rx empty after reads", d[3], 1);
  endtask

  task automatic t_r2t();
    logic [9:0] d;
    logic [9:0] v [4] = '{10'h055, 10'h166, 10'h2AA, 10'h3F0};
    do_reset();
    wr(2'd1, 10'h3);
    wr(2'd0, 10'h10);
    for (int i = 0; i < 4; i++) send_ser(v[i]);
    repeat (60) @(negedge clk);
    chk("R6 echoed word count", nw, 4);
    for (int i = 0; i < 4; i++) chk("R6 echoed word", mon_w[i], v[i]);
    for (int i = 0; i < 4; i++) begin
      rd(2'd2, d); chk("R6 rx copy kept", d, v[i]);
    end
  endtask

  task automatic t_t2r();
    logic [9:0] d;
    do_reset();
    wr(2'd0, 10'h01);
    wr(2'd1, 10'h3);
    ser_rx_valid = 1'b1; ser_rx_bit = 1'b1;   // external junk, must be ignored
    wr(2'd2, 10'h1A5);
    repeat (40) @(negedge clk);
    ser_rx_valid = 1'b0;
    chk("R7 sent once", nw, 1);
    rd(2'd2, d); chk("R7 looped word", d, 10'h1A5);
    rd(2'd3, d); chk("R7 external ignored", d[3], 1);
    wr(2'd1, 10'h1);                          // tx enable off: external path
    send_ser(10'h0C3);
    rd(2'd2, d); chk("R7 external when not both enabled", d, 10'h0C3);
  endtask

  task automatic t_both();
    logic [9:0] d;
    do_reset();
    wr(2'd0, 10'h11);
    wr(2'd1, 10'h3);
    wr(2'd2, 10'h2E7);
    repeat (100) @(negedge clk);
    chk("R8 no endless echo", nw, 1);
    rd(2'd2, d); chk("R8 looped into rx", d, 10'h2E7);
    rd(2'd3, d); chk("R8 tx empty", d[2], 1);
  endtask

  task automatic t_fifo_test();
    logic [9:0] d;
    do_reset();
    wr(2'd2, 10'h3B4);
    wr(2'd0, 10'h04);
    wr(2'd1, 10'h2);
    repeat (40) @(negedge clk);
    chk("R9 serializer halted", nw, 0);
    wr(2'd2, 10'h1D2);
    rd(2'd3, d); chk("R9 write went to rx", d, 10'h0);
    rd(2'd2, d); chk("R9 read pops tx", d, 10'h3B4);
    rd(2'd3, d); chk("R10 status tag and flags", d, 10'h7);
    wr(2'd0, 10'h00);
    wr(2'd1, 10'h0);
    rd(2'd2, d); chk("R9 rx holds swapped write", d, 10'h1D2);
  endtask

  task automatic t_full();
    logic [9:0] d;
    do_reset();
    for (int i = 0; i < 18; i++) wr(2'd2, 10'(i));
    wr(2'd0, 10'h04);
    for (int i = 0; i < 16; i++) begin
      rd(2'd2, d); chk("R11 stored entry", d, 10'(i));
    end
    rd(2'd3, d); chk("R11 extra writes dropped", d[2], 1);
  endtask

  task automatic t_soft();
    logic [9:0] d;
    do_reset();
    wr(2'd0, 10'h12);
    wr(2'd2, 10'h0AB);
    wr(2'd0, 10'h3F);
    rd(2'd0, d); chk("R2 only soft bit set", d, 10'h20);
    wr(2'd1, 10'h3);
    rd(2'd1, d); chk("R2 ctrl held", d, 0);
    wr(2'd2, 10'h0CD);
    rd(2'd3, d); chk("R2 fifos flushed", d, 10'hC);
    repeat (5) @(negedge clk);
    rd(2'd0, d); chk("R2 soft bit self-holding", d, 10'h20);
    wr(2'd0, 10'h00);
    rd(2'd0, d); chk("R2 cleared by write 0", d, 0);
    wr(2'd0, 10'h20);
    do_reset();
    rd(2'd0, d); chk("R3 hw reset clears soft", d, 0);
  endtask

  task automatic t_spare_bits();
    logic [9:0] d;
    do_reset();
    wr(2'd0, 10'h0A);
    rd(2'd0, d); chk("R12 crc/addr bits read back", d, 10'h0A);
    wr(2'd1, 10'h2);
    wr(2'd2, 10'h0F0);
    repeat (30) @(negedge clk);
    chk("R12 path unchanged count", nw, 1);
    chk("R12 path unchanged word", mon_w[0], 10'h0F0);
  endtask

  initial begin
    t_reset();
    t_normal_tx();
    t_rx();
    t_r2t();
    t_t2r();
    t_both();
    t_fifo_test();
    t_full();
    t_soft();
    t_spare_bits();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule